// File: doc/BRIEF.md
# Oversampled Serial Receive Buffer with Arrival and Idle Interrupts

This block receives asynchronous serial frames on a single idle-high line, turns each one into a parallel byte, and stores it in an on-chip first-in first-out buffer. Each stored entry carries the byte and two error tags. A frame is recognised by a falling edge on the line, and the line is oversampled so that every bit is read near its middle. When parity is enabled, it is checked as even or odd. A stop bit read as low is marked as a framing error. A consumer drains the buffer through a show-ahead pop port.

The block signals the consumer through a single-cycle "arrived" pulse. The pulse fires in two cases: when the buffer fill reaches a fixed threshold, or when bytes are stored and no further frame has ended within a programmable number of clock cycles. Flow control toward the far end uses a request-to-send output with hysteresis. The output goes high when the buffer nears full and falls again once the buffer has drained below half. If a frame ends while the buffer is full, that byte is discarded and a single-cycle overflow pulse is produced.

Top module: `uart_rx_buffer`

## Requirements
- R1: Reception starts only on a high-to-low transition of the synchronised line. The start bit is confirmed low at its midpoint, half a bit period after the edge. A low pulse that has ended by that point produces no byte.
- R2: Data bits are sampled at their centres, least significant bit first, and are stored in arrival order. pop_data_o always shows the oldest entry.
- R3: With parity_en_i high, one parity bit follows the data. If parity_odd_i is 0, the data ones plus the parity bit must be even; if it is 1, that total must be odd. A mismatch stores the byte with pop_perr_o = 1. With parity disabled, pop_perr_o is always 0.
- R4: A stop bit sampled low stores the byte with pop_ferr_o = 1. A stop bit sampled high stores it with pop_ferr_o = 0.
- R5: fill_o gives the stored count. fifo_full_o is high exactly when fill_o equals DEPTH, and fifo_empty_o is high exactly when fill_o is 0. A pop while the buffer is empty changes nothing.
- R6: A write that brings fill_o to THRESH produces exactly one arrived_irq_o pulse.
- R7: Every received frame restarts an idle count. When the count reaches idle_limit_i, arrived_irq_o pulses once if the buffer is not empty. The count then stops until the next frame.
- R8: A frame that ends while the buffer is full is dropped. overflow_o then pulses for one cycle, and fill_o and the stored contents stay unchanged.
- R9: rts_o rises when fill_o is DEPTH-4 or more, and falls when fill_o drops below DEPTH/2. Between those levels it holds its value.
- R10: After reset the buffer is empty, and rts_o, arrived_irq_o and overflow_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| parity_en_i | input | 1 | A parity bit follows the data bits |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| idle_limit_i | input | TW | Idle time, in clock cycles, before the timeout pulse |
| pop_i | input | 1 | Remove the oldest entry |
| pop_data_o | output | DATA_W | Oldest stored byte |
| pop_perr_o | output | 1 | Parity error tag of the oldest entry |
| pop_ferr_o | output | 1 | Framing error tag of the oldest entry |
| fifo_empty_o | output | 1 | Buffer holds no entries |
| fifo_full_o | output | 1 | Buffer holds DEPTH entries |
| fill_o | output | $clog2(DEPTH+1) | Number of stored entries |
| arrived_irq_o | output | 1 | One-cycle pulse on threshold or idle timeout |
| overflow_o | output | 1 | One-cycle pulse when a byte is dropped |
| rts_o | output | 1 | High asks the far end to pause |

## Verification
Every cycle, the assertions check that the full and empty flags agree with the fill count. They also check that the flags are never high together, that an overflow pulse only follows a full buffer, and that each edge of rts_o happens on the correct side of its two levels. Other behaviours can only be shown by the bench's scenarios with serial stimulus. These are the bit-centre sampling, the rejection of a short glitch, parity in both senses, the framing tag, the exact timing of the threshold and idle pulses, and the silence of the timer after the buffer has been drained.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser #(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  import uart_rx_pkg::*;
  localparam int OW  = $clog2(OVS);
  localparam int BW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int DVW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [OW-1:0]  OVS_LAST  = OW'(OVS - 1);
  localparam logic [OW-1:0]  HALF_LAST = OW'(OVS / 2 - 1);
  localparam logic [BW-1:0]  BIT_LAST  = BW'(DATA_W - 1);
  localparam logic [DVW-1:0] DIV_LAST  = DVW'(TICK_DIV - 1);

  logic              sync1_q, sync2_q, prev_q;
  logic [DVW-1:0]    div_q;
  logic              tick;
  rx_state_e         state_q, state_d;
  logic [OW-1:0]     ovs_q, ovs_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              par_q, par_d;

  // two-flop synchronizer plus edge history, oversampling tick divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
      div_q   <= '0;
    end else begin
      sync1_q <= rx_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      div_q   <= tick ? '0 : div_q + 1'b1;
    end
  end

  assign tick = (div_q == DIV_LAST);

  always_comb begin
    state_d = state_q;
    ovs_d   = ovs_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    par_d   = par_q;
    done_o  = 1'b0;
    ferr_o  = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        ovs_d = '0;
        bit_d = '0;
        if (prev_q && !sync2_q) state_d = RX_START;
      end
      RX_START: if (tick) begin
        if (ovs_q == HALF_LAST) begin
          ovs_d   = '0;
          state_d = sync2_q ? RX_IDLE : RX_DATA;
        end else ovs_d = ovs_q + 1'b1;
      end
      RX_DATA: if (tick) begin
        if (ovs_q == OVS_LAST) begin
          ovs_d   = '0;
          shift_d = {sync2_q, shift_q[DATA_W-1:1]};
          bit_d   = bit_q + 1'b1;
          if (bit_q == BIT_LAST) state_d = parity_en_i ? RX_PAR : RX_STOP;
        end else ovs_d = ovs_q + 1'b1;
      end
      RX_PAR: if (tick) begin
        if (ovs_q == OVS_LAST) begin
          ovs_d   = '0;
          par_d   = sync2_q;
          state_d = RX_STOP;
        end else ovs_d = ovs_q + 1'b1;
      end
      RX_STOP: if (tick) begin
        if (ovs_q == OVS_LAST) begin
          ovs_d   = '0;
          done_o  = 1'b1;
          ferr_o  = !sync2_q;
          state_d = RX_IDLE;
        end else ovs_d = ovs_q + 1'b1;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      ovs_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovs_q   <= ovs_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      par_q   <= par_d;
    end
  end

  assign data_o = shift_q;
  assign perr_o = parity_en_i & ((^shift_q) ^ par_q ^ parity_odd_i);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [W-1:0]               wdata_i,
  input  logic                       rd_i,
  output logic [W-1:0]               rdata_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] fill_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic          full_q, empty_q, full_d, empty_d;
  logic [FW-1:0] fill_q;
  logic          we, re;

  assign we = wr_i & !full_q;
  assign re = rd_i & !empty_q;

  // equal pointers are resolved by which operation made them meet
  always_comb begin
    full_d  = full_q;
    empty_d = empty_q;
    if (we && !re) begin
      full_d  = (AW'(wptr_q + 1'b1) == rptr_q);
      empty_d = 1'b0;
    end else if (re && !we) begin
      empty_d = (AW'(rptr_q + 1'b1) == wptr_q);
      full_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      fill_q  <= '0;
    end else begin
      if (we) wptr_q <= wptr_q + 1'b1;
      if (re) rptr_q <= rptr_q + 1'b1;
      full_q  <= full_d;
      empty_q <= empty_d;
      if (we != re) fill_q <= we ? fill_q + 1'b1 : fill_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (wptr_q == AW'(g))) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[rptr_q];
  assign full_o  = full_q;
  assign empty_o = empty_q;
  assign fill_o  = fill_q;
endmodule

// File: rtl/uart_rx_events.sv
module uart_rx_events #(
  parameter int DEPTH  = 64,
  parameter int THRESH = 64,
  parameter int TW     = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       done_i,
  input  logic                       full_i,
  input  logic                       empty_i,
  input  logic                       we_i,
  input  logic                       re_i,
  input  logic [$clog2(DEPTH+1)-1:0] fill_i,
  input  logic [TW-1:0]              idle_limit_i,
  output logic                       irq_o,
  output logic                       ovf_o,
  output logic                       rts_o
);
  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] THR_PRE = FW'(THRESH - 1);
  localparam logic [FW-1:0] RTS_ON  = FW'(DEPTH - 4);
  localparam logic [FW-1:0] RTS_OFF = FW'(DEPTH / 2);

  logic          run_q, run_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          irq_q, irq_d, ovf_q, ovf_d, rts_q, rts_d;
  logic          thr_hit, idle_hit;

  always_comb begin
    run_d    = run_q;
    cnt_d    = cnt_q;
    idle_hit = 1'b0;
    if (done_i) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      if (cnt_q == idle_limit_i) begin
        run_d    = 1'b0;
        idle_hit = !empty_i;
      end else cnt_d = cnt_q + 1'b1;
    end
    thr_hit = we_i && !re_i && (fill_i == THR_PRE);
    irq_d   = thr_hit | idle_hit;
    ovf_d   = done_i & full_i;
    rts_d   = rts_q;
    if (fill_i >= RTS_ON)      rts_d = 1'b1;
    else if (fill_i < RTS_OFF) rts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
      rts_q <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      ovf_q <= ovf_d;
      rts_q <= rts_d;
    end
  end

  assign irq_o = irq_q;
  assign ovf_o = ovf_q;
  assign rts_o = rts_q;
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 64,
  parameter int THRESH   = 64,
  parameter int OVS      = 16,
  parameter int TICK_DIV = 4,
  parameter int TW       = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_i,
  input  logic                       parity_en_i,
  input  logic                       parity_odd_i,
  input  logic [TW-1:0]              idle_limit_i,
  input  logic                       pop_i,
  output logic [DATA_W-1:0]          pop_data_o,
  output logic                       pop_perr_o,
  output logic                       pop_ferr_o,
  output logic                       fifo_empty_o,
  output logic                       fifo_full_o,
  output logic [$clog2(DEPTH+1)-1:0] fill_o,
  output logic                       arrived_irq_o,
  output logic                       overflow_o,
  output logic                       rts_o
);
  localparam int EW = DATA_W + 2;
  localparam int FW = $clog2(DEPTH + 1);

  logic              rst_meta_q, rst_sync_q;
  logic              done;
  logic [DATA_W-1:0] rx_data;
  logic              perr, ferr, we, re;
  logic [EW-1:0]     rd_entry;
  logic [FW-1:0]     fill;
  logic              full, empty;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  uart_rx_deser #(.DATA_W(DATA_W), .OVS(OVS), .TICK_DIV(TICK_DIV)) i_deser (
    .clk(clk), .rst_n(rst_sync_q), .rx_i(rx_i),
    .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i),
    .done_o(done), .data_o(rx_data), .perr_o(perr), .ferr_o(ferr)
  );

  assign we = done & !full;
  assign re = pop_i & !empty;

  uart_rx_fifo #(.W(EW), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_sync_q), .wr_i(we), .wdata_i({perr, ferr, rx_data}),
    .rd_i(re), .rdata_o(rd_entry), .full_o(full), .empty_o(empty), .fill_o(fill)
  );

  uart_rx_events #(.DEPTH(DEPTH), .THRESH(THRESH), .TW(TW)) i_events (
    .clk(clk), .rst_n(rst_sync_q), .done_i(done), .full_i(full), .empty_i(empty),
    .we_i(we), .re_i(re), .fill_i(fill), .idle_limit_i(idle_limit_i),
    .irq_o(arrived_irq_o), .ovf_o(overflow_o), .rts_o(rts_o)
  );

  assign pop_data_o   = rd_entry[DATA_W-1:0];
  assign pop_ferr_o   = rd_entry[DATA_W];
  assign pop_perr_o   = rd_entry[DATA_W+1];
  assign fifo_empty_o = empty;
  assign fifo_full_o  = full;
  assign fill_o       = fill;
endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
  parameter int DEPTH = 64,
  parameter int FW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_empty_o,
  input logic          fifo_full_o,
  input logic [FW-1:0] fill_o,
  input logic          overflow_o,
  input logic          rts_o
);
  AST_FULL_MATCHES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full_o == (int'(fill_o) == DEPTH)); // R5
  AST_EMPTY_MATCHES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty_o == (fill_o == '0)); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full_o && fifo_empty_o)); // R5
  AST_OVF_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> $past(fifo_full_o)); // R8
  AST_RTS_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_o) |-> (int'($past(fill_o)) >= DEPTH - 4)); // R9
  AST_RTS_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_o) |-> (int'($past(fill_o)) < DEPTH / 2)); // R9
endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH), .FW(FW)) i_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty_o(fifo_empty_o), .fifo_full_o(fifo_full_o),
  .fill_o(fill_o), .overflow_o(overflow_o), .rts_o(rts_o)
);

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;
  localparam int DW = 8, DEPTH = 16, THRESH = 10, OVS = 16, DIV = 2, TW = 16;
  localparam int BIT = OVS * DIV;
  localparam int FW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, par_en = 1'b0, par_odd = 1'b0, pop = 1'b0;
  logic [TW-1:0] idle_limit = 16'd3000;
  logic [DW-1:0] pdata;
  logic pperr, pferr, empty, full, irq, ovf, rts;
  logic [FW-1:0] fill;

  int errors = 0, checks = 0, cyc = 0, irq_cnt = 0, ovf_cnt = 0;
  int fill_rise_cyc = 0, irq_cyc = 0, model_fill = 0;
  bit finished = 0;
  logic [DW+1:0] exp_q [$];
  logic [FW-1:0] fill_prev = '0;

  always #2.5 clk = ~clk;

  uart_rx_buffer #(.DATA_W(DW), .DEPTH(DEPTH), .THRESH(THRESH), .OVS(OVS),
                   .TICK_DIV(DIV), .TW(TW)) i_uart_rx_buffer (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .parity_en_i(par_en), .parity_odd_i(par_odd),
    .idle_limit_i(idle_limit), .pop_i(pop), .pop_data_o(pdata), .pop_perr_o(pperr),
    .pop_ferr_o(pferr), .fifo_empty_o(empty), .fifo_full_o(full), .fill_o(fill),
    .arrived_irq_o(irq), .overflow_o(ovf), .rts_o(rts)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (irq) begin irq_cnt <= irq_cnt + 1; irq_cyc <= cyc; end
    if (ovf) ovf_cnt <= ovf_cnt + 1;
    if (fill_prev == '0 && fill != '0) fill_rise_cyc <= cyc;
    fill_prev <= fill;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: sends one frame and records the entry the buffer should hold
  task automatic send(input logic [DW-1:0] d, input bit use_par, input bit pbit, input bit stopv);
    bit perr_exp;
    perr_exp = use_par && (((^d) ^ pbit ^ par_odd) != 1'b0);
    @(negedge clk) rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < DW; i++) begin
      rx = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (use_par) begin
      rx = pbit;
      repeat (BIT) @(negedge clk);
    end
    rx = stopv;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    repeat (BIT / 2) @(negedge clk);
    if (model_fill < DEPTH) begin
      exp_q.push_back({perr_exp, !stopv, d});
      model_fill++;
    end
  endtask

  // monitor side of the scoreboard: pop the oldest entry and compare
  task automatic drain_one(input string req);
    logic [DW+1:0] e;
    @(negedge clk);
    if (exp_q.size() == 0) begin
      chk({req, " scoreboard underflow"}, 1, 0);
      return;
    end
    e = exp_q.pop_front();
    chk({req, " data"}, int'(pdata), int'(e[DW-1:0]));
    chk({req, " ferr"}, int'(pferr), int'(e[DW]));
    chk({req, " perr"}, int'(pperr), int'(e[DW+1]));
    pop = 1'b1;
    @(negedge clk) pop = 1'b0;
    model_fill--;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 empty", int'(empty), 1);
    chk("R10 full", int'(full), 0);
    chk("R10 fill", int'(fill), 0);
    chk("R10 rts", int'(rts), 0);
    chk("R10 irq+ovf", int'(irq) + int'(ovf), 0);

    // R2: plain frames, LSB first, kept in order
    send(8'hA5, 0, 0, 1);
    send(8'h3C, 0, 0, 1);
    send(8'h00, 0, 0, 1);
    send(8'hFF, 0, 0, 1);
    chk("R2 fill after four", int'(fill), 4);
    repeat (4) drain_one("R2");

    // R1: a short low pulse is rejected by the mid-start check
    @(negedge clk) rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    chk("R1 glitch ignored", int'(fill), 0);

    // R3: even and odd parity, matching and mismatching bits
    par_en = 1'b1;
    par_odd = 1'b0;
    send(8'h07, 1, 1, 1);
    send(8'h07, 1, 0, 1);
    par_odd = 1'b1;
    send(8'h81, 1, 1, 1);
    send(8'h81, 1, 0, 1);
    repeat (2) drain_one("R3 even");
    repeat (2) drain_one("R3 odd");
    par_en = 1'b0;
    par_odd = 1'b0;

    // R4: low stop bit tags framing error, next frame clean
    send(8'h5A, 0, 0, 0);
    repeat (BIT) @(negedge clk);
    send(8'hC3, 0, 0, 1);
    repeat (2) drain_one("R4");

    // R5: pop on empty has no effect
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 pop on empty fill", int'(fill), 0);
    chk("R5 pop on empty flag", int'(empty), 1);

    // R7: idle timeout fires once, L+1 cycles after the write
    idle_limit = 16'd300;
    repeat (2) @(negedge clk);
    d0 = irq_cnt;
    send(8'h11, 0, 0, 1);
    repeat (400) @(negedge clk);
    chk("R7 one timeout pulse", irq_cnt - d0, 1);
    chk("R7 timeout delay in window",
        int'((irq_cyc - fill_rise_cyc) >= 300 && (irq_cyc - fill_rise_cyc) <= 302), 1);
    repeat (400) @(negedge clk);
    chk("R7 timer stops after firing", irq_cnt - d0, 1);
    drain_one("R7");
    // R7: drained before the limit, so no pulse
    d0 = irq_cnt;
    send(8'h22, 0, 0, 1);
    drain_one("R7 drained");
    repeat (500) @(negedge clk);
    chk("R7 no pulse when empty", irq_cnt - d0, 0);

    // R6 / R9 / R5 / R8: fill the buffer back to back
    idle_limit = 16'd3000;
    d0 = irq_cnt;
    for (int i = 0; i < THRESH - 1; i++) send(8'(8'h40 + i), 0, 0, 1);
    chk("R6 no pulse below threshold", irq_cnt - d0, 0);
    send(8'h60, 0, 0, 1);
    chk("R6 one pulse at threshold", irq_cnt - d0, 1);
    send(8'h61, 0, 0, 1);
    chk("R9 rts low at 11", int'(rts), 0);
    send(8'h62, 0, 0, 1);
    chk("R9 rts high at 12", int'(rts), 1);
    for (int i = 0; i < 4; i++) send(8'(8'h70 + i), 0, 0, 1);
    chk("R5 full at depth", int'(full), 1);
    chk("R6 no extra pulse", irq_cnt - d0, 1);
    d0 = ovf_cnt;
    send(8'hEE, 0, 0, 1);
    chk("R8 overflow pulse", ovf_cnt - d0, 1);
    chk("R8 fill unchanged", int'(fill), DEPTH);
    repeat (8) drain_one("R8/R2 order");
    repeat (2) @(negedge clk);
    chk("R9 rts held at 8", int'(rts), 1);
    drain_one("R9");
    repeat (2) @(negedge clk);
    chk("R9 rts low at 7", int'(rts), 0);
    while (exp_q.size() > 0) drain_one("R8 no dropped byte");
    repeat (2) @(negedge clk);
    chk("R8 drained empty", int'(empty), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule